// File: doc/BRIEF.md
# Manchester Line Receiver with Preamble Hunt

This block recovers bytes from a Manchester-coded serial line that is sampled once per pulse of a 16x oversampling tick. Each bit cell carries exactly one transition in its middle, and the direction of that transition gives the bit value. The selected polarity decides which direction means 0. The receiver sits idle and hunts for a mid-bit edge. If a preamble length is programmed, it first demands that many bits of the chosen preamble pattern. It then expects a start bit of 0, eight data bits sent least significant bit first, and a stop bit.

A drift option re-centres the receiver's phase counter on every accepted mid-bit edge. This lets it follow a transmitter whose bit period is somewhat longer or shorter than 16 ticks. Without the option the phase counter free-runs, and accumulated drift eventually pushes an edge out of the acceptance window. The block reports each finished byte with a one-clock strobe. It raises a one-clock flag when a frame bit has no mid-bit transition, and it marks a byte whose stop bit decodes as 0.

Top module: `man_rx`

## Requirements
- R1: With polarity 0, a low-to-high mid-bit transition decodes as 0 and a high-to-low one as 1.
- R2: With polarity 1 the mapping of R1 is inverted: high-to-low is 0 and low-to-high is 1.
- R3: A frame is a start bit of 0, eight data bits with the least significant bit first, and a stop bit. On the stop bit, `byte_o` is loaded and `byte_vld_o` is high for exactly one clock. `byte_o` does not change at any other time.
- R4: When the stop bit decodes as 0, `stop_bad_o` is high in the same clock as `byte_vld_o`. It is never high without it.
- R5: A preamble length of 0 disables the preamble: the first decoded 0 is taken as the start bit.
- R6: `pre_kind_i` selects the expected preamble: 0 all ones, 1 all zeros, 2 alternating starting with 0, 3 alternating starting with 1.
- R7: A preamble length N from 1 to 15 requires N consecutive matching preamble bits before the start bit. A frame sent without the preamble produces no byte and no error.
- R8: Once the start bit has been accepted, a data or stop bit cell with no transition inside the window of phases 4 to 12 raises `code_err_o` for one clock. The receiver then returns to hunting, and the next clean frame is received normally.
- R9: With drift compensation on, frames whose bit period is 15 or 17 ticks are received correctly.
- R10: With drift compensation off and a 17-tick bit period, the fifth bit after the start bit falls outside the window, and `code_err_o` is raised.
- R11: After reset, `byte_vld_o`, `stop_bad_o`, `code_err_o` and `byte_o` are all 0.
- R12: `byte_vld_o` and `code_err_o` rise only in the clock that follows a clock in which `tick16_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous Manchester serial line |
| tick16_i | input | 1 | One-clock pulse at 16 times the nominal bit rate |
| pol_i | input | 1 | Receive polarity (see R1, R2) |
| pre_kind_i | input | 2 | Expected preamble pattern (see R6) |
| pre_len_i | input | PLEN_W (4) | Preamble length in bits, 0 disables |
| drift_en_i | input | 1 | Re-centre the phase on each accepted mid-bit edge |
| byte_o | output | DATA_W (8) | Last received byte |
| byte_vld_o | output | 1 | One-clock strobe for a finished byte |
| stop_bad_o | output | 1 | Stop bit of the strobed byte decoded as 0 |
| code_err_o | output | 1 | One-clock flag for a missing mid-bit transition |

## Verification
The hardest state to reach is the drift-induced window miss. Provoking it needs a transmitter whose bit period differs from 16 ticks, with enough bits that the phase error accumulates past the window edge, and it needs a bit pattern with no cell-boundary transitions that could be mistaken for mid-bit edges. The bench generates line waveforms whose half-cell lengths are set in tick units, so bit periods of 15, 16 and 17 ticks are exact. It sends an alternating pattern of start plus five data bits with drift compensation off, and the same periods as full frames with it on. Preamble rejection is reached by sending a frame that has no preamble while a length of 4 is programmed. The data bits are chosen so that the receiver's partial matches all collapse without producing any output.

// File: rtl/man_rx_pkg.sv
package man_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_PRE   = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_t;

  typedef enum logic [1:0] {
    PRE_ONES  = 2'd0,
    PRE_ZEROS = 2'd1,
    PRE_ZO    = 2'd2,
    PRE_OZ    = 2'd3
  } pre_kind_t;

  // expected preamble bit for a given pattern, at an even or odd position
  function automatic logic pre_expect(pre_kind_t kind, logic odd);
    case (kind)
      PRE_ONES:  pre_expect = 1'b1;
      PRE_ZEROS: pre_expect = 1'b0;
      PRE_ZO:    pre_expect = odd;
      default:   pre_expect = ~odd;
    endcase
  endfunction

endpackage

// File: rtl/man_rx_sync.sv
module man_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/man_rx_phase.sv
module man_rx_phase #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic line_i,
  input  logic pol_i,
  input  logic drift_i,
  input  logic locked_i,
  output logic bit_stb_o,
  output logic bit_val_o,
  output logic miss_o
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PH_LAST   = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_RESYNC = PW'(OVS / 2 + 1);
  localparam logic [PW-1:0] WIN_LO    = PW'(OVS / 4);
  localparam logic [PW-1:0] WIN_HI    = PW'((3 * OVS) / 4);
  localparam logic [PW-1:0] WIN_CLR   = PW'((3 * OVS) / 4 + 1);

  logic          smp;
  logic [PW-1:0] ph;
  logic          seen;
  logic          edge_s, in_win, take;

  always_comb begin
    edge_s = tick_i && (line_i != smp);
    in_win = (ph >= WIN_LO) && (ph <= WIN_HI);
    take   = edge_s && (!locked_i || (in_win && !seen));
  end

  assign bit_stb_o = take;
  assign bit_val_o = ~line_i ^ pol_i;
  assign miss_o    = tick_i && locked_i && (ph == WIN_HI) && !seen && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp  <= 1'b0;
      ph   <= '0;
      seen <= 1'b0;
    end else if (tick_i) begin
      smp <= line_i;
      if (take && (!locked_i || drift_i)) ph <= PH_RESYNC;
      else if (ph == PH_LAST)             ph <= '0;
      else                                ph <= ph + 1'b1;
      if (take)                 seen <= 1'b1;
      else if (ph == WIN_CLR)   seen <= 1'b0;
    end
  end
endmodule

// File: rtl/man_rx_frame.sv
module man_rx_frame
  import man_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic              miss_i,
  input  logic [1:0]        kind_i,
  input  logic [PLEN_W-1:0] plen_i,
  output logic              locked_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              stop_bad_o,
  output logic              code_err_o
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(DATA_W - 1);

  rx_state_t         st;
  logic [PLEN_W-1:0] pcnt, pidx, pnext;
  logic [CW-1:0]     dcnt;
  logic [DATA_W-1:0] shreg;
  logic              exp_b, pre_ok;

  always_comb begin
    pidx   = (st == ST_HUNT) ? '0 : pcnt;
    pnext  = pidx + 1'b1;
    exp_b  = pre_expect(pre_kind_t'(kind_i), pidx[0]);
    pre_ok = (bit_val_i == exp_b);
  end

  assign locked_o = (st != ST_HUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_HUNT;
      pcnt       <= '0;
      dcnt       <= '0;
      shreg      <= '0;
      data_o     <= '0;
      valid_o    <= 1'b0;
      stop_bad_o <= 1'b0;
      code_err_o <= 1'b0;
    end else begin
      valid_o    <= 1'b0;
      stop_bad_o <= 1'b0;
      code_err_o <= 1'b0;
      if (bit_stb_i) begin
        case (st)
          ST_HUNT: begin
            if (plen_i == '0) begin
              if (!bit_val_i) begin
                st   <= ST_DATA;
                dcnt <= '0;
              end
            end else if (pre_ok) begin
              pcnt <= pnext;
              st   <= (pnext == plen_i) ? ST_START : ST_PRE;
            end
          end
          ST_PRE: begin
            if (pre_ok) begin
              pcnt <= pnext;
              if (pnext == plen_i) st <= ST_START;
            end else begin
              st <= ST_HUNT;
            end
          end
          ST_START: begin
            st   <= bit_val_i ? ST_HUNT : ST_DATA;
            dcnt <= '0;
          end
          ST_DATA: begin
            shreg <= {bit_val_i, shreg[DATA_W-1:1]};
            dcnt  <= dcnt + 1'b1;
            if (dcnt == LAST_IDX) st <= ST_STOP;
          end
          ST_STOP: begin
            data_o     <= shreg;
            valid_o    <= 1'b1;
            stop_bad_o <= !bit_val_i;
            st         <= ST_HUNT;
          end
          default: st <= ST_HUNT;
        endcase
      end else if (miss_i) begin
        if (st == ST_DATA || st == ST_STOP) code_err_o <= 1'b1;
        st <= ST_HUNT;
      end
    end
  end
endmodule

// File: rtl/man_rx.sv
module man_rx #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int PLEN_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_i,
  input  logic              tick16_i,
  input  logic              pol_i,
  input  logic [1:0]        pre_kind_i,
  input  logic [PLEN_W-1:0] pre_len_i,
  input  logic              drift_en_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              stop_bad_o,
  output logic              code_err_o
);
  logic line_s, bit_stb, bit_val, miss, locked;

  man_rx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (line_i),
    .q_o (line_s)
  );

  man_rx_phase #(.OVS(OVS)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick16_i),
    .line_i    (line_s),
    .pol_i     (pol_i),
    .drift_i   (drift_en_i),
    .locked_i  (locked),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val),
    .miss_o    (miss)
  );

  man_rx_frame #(.DATA_W(DATA_W), .PLEN_W(PLEN_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .bit_stb_i  (bit_stb),
    .bit_val_i  (bit_val),
    .miss_i     (miss),
    .kind_i     (pre_kind_i),
    .plen_i     (pre_len_i),
    .locked_o   (locked),
    .data_o     (byte_o),
    .valid_o    (byte_vld_o),
    .stop_bad_o (stop_bad_o),
    .code_err_o (code_err_o)
  );
endmodule

// File: rtl/man_rx_chk.sv
module man_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick16_i,
  input logic [DATA_W-1:0] byte_o,
  input logic              byte_vld_o,
  input logic              stop_bad_o,
  input logic              code_err_o
);
  // R3: strobe lasts one clock
  a_r3_vld_one_clk: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |=> !byte_vld_o);

  // R3: byte only changes with the strobe
  a_r3_byte_hold: assert property (@(posedge clk) disable iff (rst)
    !byte_vld_o |-> $stable(byte_o));

  // R4: stop flag only with the strobe
  a_r4_stop_with_vld: assert property (@(posedge clk) disable iff (rst)
    stop_bad_o |-> byte_vld_o);

  // R8: code error lasts one clock and never coincides with a byte
  a_r8_err_one_clk: assert property (@(posedge clk) disable iff (rst)
    code_err_o |=> !code_err_o);

  a_r8_err_not_vld: assert property (@(posedge clk) disable iff (rst)
    !(code_err_o && byte_vld_o));

  // R12: outputs follow a tick
  a_r12_vld_after_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(byte_vld_o) |-> $past(tick16_i));

  a_r12_err_after_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(code_err_o) |-> $past(tick16_i));
endmodule

bind man_rx man_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick16_i   (tick16_i),
  .byte_o     (byte_o),
  .byte_vld_o (byte_vld_o),
  .stop_bad_o (stop_bad_o),
  .code_err_o (code_err_o)
);

// File: tb/man_rx_tb.sv
module man_rx_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       line = 1'b0, pol = 1'b0, drift = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [3:0] plen = 4'd0;
  logic [1:0] div;
  logic       tick, tick_seen;
  int         tick_cnt = 0;

  logic [7:0] byte_o;
  logic       byte_vld_o, stop_bad_o, code_err_o;

  always_ff @(posedge clk) begin
    if (rst) div <= '0;
    else     div <= div + 2'd1;
  end
  assign tick = (div == 2'd3) && !rst;

  always @(posedge clk) begin
    tick_seen <= tick;
    if (tick) tick_cnt <= tick_cnt + 1;
  end

  man_rx u_dut (
    .clk        (clk),
    .rst        (rst),
    .line_i     (line),
    .tick16_i   (tick),
    .pol_i      (pol),
    .pre_kind_i (kind),
    .pre_len_i  (plen),
    .drift_en_i (drift),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o),
    .stop_bad_o (stop_bad_o),
    .code_err_o (code_err_o)
  );

  int n_run = 0, n_fail = 0;

  // expected event queue: kind 1 = byte, kind 2 = code error
  int         q_kind[$];
  logic [7:0] q_data[$];
  logic       q_bad[$];
  string      q_req[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int         m_kind;
  logic [7:0] m_data;
  logic       m_bad;
  string      m_req;

  always @(negedge clk) begin
    if (!rst) begin
      if (stop_bad_o && !byte_vld_o) check(1'b0, "R4", "stop flag without strobe", 1, 0);
      if (byte_vld_o || code_err_o) begin
        check(tick_seen, "R12", "event without preceding tick", 0, 1);
        if (q_kind.size() == 0) begin
          check(1'b0, "R3", "unexpected event {vld,err}", {byte_vld_o, code_err_o}, 0);
        end else begin
          m_kind = q_kind.pop_front();
          m_data = q_data.pop_front();
          m_bad  = q_bad.pop_front();
          m_req  = q_req.pop_front();
          if (m_kind == 1) begin
            check(byte_vld_o && !code_err_o, m_req, "strobe type {vld,err}",
                  {byte_vld_o, code_err_o}, 2);
            check(byte_o == m_data, m_req, "byte value", byte_o, m_data);
            check(stop_bad_o == m_bad, m_req, "stop flag", stop_bad_o, m_bad);
          end else begin
            check(code_err_o && !byte_vld_o, m_req, "code error {vld,err}",
                  {byte_vld_o, code_err_o}, 1);
          end
        end
      end
    end
  end

  task automatic wait_ticks(int n);
    int tgt;
    tgt = tick_cnt + n;
    while (tick_cnt < tgt) @(negedge clk);
  endtask

  function automatic logic pre_bit(int i);
    case (kind)
      2'd0:    return 1'b1;
      2'd1:    return 1'b0;
      2'd2:    return i[0];
      default: return ~i[0];
    endcase
  endfunction

  task automatic put_bit(logic b, int per);
    logic fh;
    fh   = b ^ pol;
    line = fh;
    wait_ticks(8);
    line = ~fh;
    wait_ticks(per - 8);
  endtask

  task automatic send(int npre, logic [7:0] byt, logic stopb, int per, int nbits, bit with_stop);
    logic b0;
    b0   = (npre > 0) ? pre_bit(0) : 1'b0;
    line = b0 ^ pol;
    wait_ticks(48);
    for (int i = 0; i < npre; i++) put_bit(pre_bit(i), per);
    put_bit(1'b0, per);
    for (int i = 0; i < nbits; i++) put_bit(byt[i], per);
    if (with_stop) put_bit(stopb, per);
    wait_ticks(48);
  endtask

  task automatic exp_byte(logic [7:0] d, logic bad, string req);
    q_kind.push_back(1); q_data.push_back(d); q_bad.push_back(bad); q_req.push_back(req);
  endtask

  task automatic exp_err(string req);
    q_kind.push_back(2); q_data.push_back(8'h00); q_bad.push_back(1'b0); q_req.push_back(req);
  endtask

  task automatic drained(string req);
    check(q_kind.size() == 0, req, "events still pending", q_kind.size(), 0);
    q_kind.delete(); q_data.delete(); q_bad.delete(); q_req.delete();
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!byte_vld_o && !stop_bad_o && !code_err_o, "R11", "flags after reset",
          {byte_vld_o, stop_bad_o, code_err_o}, 0);
    check(byte_o == 8'h00, "R11", "byte after reset", byte_o, 0);

    // R1 R3 R5: polarity 0, no preamble
    exp_byte(8'hA5, 1'b0, "R1");
    send(0, 8'hA5, 1'b1, 16, 8, 1'b1);
    drained("R1");
    exp_byte(8'h80, 1'b0, "R3");
    send(0, 8'h80, 1'b1, 16, 8, 1'b1);
    drained("R3");
    exp_byte(8'h01, 1'b0, "R5");
    send(0, 8'h01, 1'b1, 16, 8, 1'b1);
    drained("R5");

    // R2 polarity 1
    pol = 1'b1;
    exp_byte(8'h3C, 1'b0, "R2");
    send(0, 8'h3C, 1'b1, 16, 8, 1'b1);
    drained("R2");
    pol = 1'b0;

    // R4 stop bit decoding as 0
    exp_byte(8'h5A, 1'b1, "R4");
    send(0, 8'h5A, 1'b0, 16, 8, 1'b1);
    drained("R4");

    // R6 R7 preamble patterns and lengths
    kind = 2'd0; plen = 4'd4;
    exp_byte(8'hC3, 1'b0, "R6");
    send(4, 8'hC3, 1'b1, 16, 8, 1'b1);
    drained("R6");
    kind = 2'd1; plen = 4'd15;
    exp_byte(8'h0F, 1'b0, "R7");
    send(15, 8'h0F, 1'b1, 16, 8, 1'b1);
    drained("R7");
    kind = 2'd2; plen = 4'd3;
    exp_byte(8'h96, 1'b0, "R6");
    send(3, 8'h96, 1'b1, 16, 8, 1'b1);
    drained("R6");
    kind = 2'd3; plen = 4'd2;
    exp_byte(8'h69, 1'b0, "R6");
    send(2, 8'h69, 1'b1, 16, 8, 1'b1);
    drained("R6");

    // R7 missing preamble: nothing comes out
    kind = 2'd0; plen = 4'd4;
    send(0, 8'hFF, 1'b1, 16, 8, 1'b1);
    drained("R7");
    check(!byte_vld_o && !code_err_o, "R7", "output after frame without preamble",
          {byte_vld_o, code_err_o}, 0);

    // R8 flat cell inside a frame, then recovery
    plen = 4'd0;
    exp_err("R8");
    send(0, 8'h05, 1'b1, 16, 3, 1'b0);
    drained("R8");
    exp_byte(8'h11, 1'b0, "R8");
    send(0, 8'h11, 1'b1, 16, 8, 1'b1);
    drained("R8");

    // R9 drift compensation on, slow and fast transmitter
    drift = 1'b1;
    exp_byte(8'h5A, 1'b0, "R9");
    send(0, 8'h5A, 1'b1, 17, 8, 1'b1);
    drained("R9");
    exp_byte(8'hA6, 1'b0, "R9");
    send(0, 8'hA6, 1'b1, 15, 8, 1'b1);
    drained("R9");

    // R10 drift compensation off, slow transmitter, alternating bits
    drift = 1'b0;
    exp_err("R10");
    send(0, 8'h15, 1'b1, 17, 5, 1'b0);
    drained("R10");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule